// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt sources and a small processor core. Each source is configured as one of two types. A flag-type source records events in a sticky flag. A level-type source asks for service only while its input is held high. Every request is gated by its own enable bit and by one global enable. The lowest-numbered pending request wins. The block presents that request to the core as a vector index and as a vector address.

When the core accepts the request with its take strobe, the block drops the global enable. In the same step it clears the flag of the source it served. Software changes the enables and clears flags through one write port. Clearing uses write-one-to-clear. Software turns the global enable on with a set strobe. The core's disable strobe turns it off at once. The core's return strobe turns it back on. After a return, no request is offered until the core reports that one instruction has retired. A select input moves the vector table from address zero to a boot-area base.

Top module: `prio_vec_irq`

## Requirements
- R1: Source i maps to vector index i+1, and index 0 is kept for reset. When several sources are pending, the one with the lowest index wins. `vec_idx_o` is 0 when nothing is pending.
- R2: `irq_req_o` is high only when all of these hold: the global enable is on, the source's own enable bit is set, and no post-return hold-off is active.
- R3: A take (`take_i` high while `irq_req_o` is high) clears the global enable and the served source's flag at the next clock edge.
- R4: `reti_i` sets the global enable at the next edge. `gie_set_i` does the same.
- R5: For a flag-type source (`src_is_level_i[i]`=0), a high input sets its flag. The flag is set even while the source's enable or the global enable is off. It stays set until cleared, and the request is then served once enabled.
- R6: A write with `wr_sel_i`=0 replaces the enable register. A write with `wr_sel_i`=1 clears every flag whose data bit is 1. A new event in the same cycle wins over any clear.
- R7: A level-type source (`src_is_level_i[i]`=1) stores no flag. It requests only while its input is high, so a pulse seen while the source is disabled is never served.
- R8: After `reti_i`, no request is offered until the cycle after a `retire_i` pulse.
- R9: `cli_i` blocks requests in the same cycle. It clears the global enable at the next edge, and this wins over a take, a return or a set issued in the same cycle.
- R10: `vec_addr_o` equals base + `vec_idx_o` × SLOT_SIZE. The base is 0 when `boot_sel_i`=0 and BOOT_BASE when `boot_sel_i`=1.
- R11: After reset, the flags, the enables, the global enable and the hold-off are all 0, and no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Source inputs (events or levels) |
| src_is_level_i | input | NUM_SRC | Type per source: 1 = level, 0 = flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = write enables, 1 = clear flags |
| wr_data_i | input | NUM_SRC | Write data |
| gie_set_i | input | 1 | Software sets the global enable |
| cli_i | input | 1 | Core disable-interrupts strobe |
| reti_i | input | 1 | Core return-from-interrupt strobe |
| retire_i | input | 1 | Core instruction-retired strobe |
| take_i | input | 1 | Core accepts the offered request |
| boot_sel_i | input | 1 | Selects the boot vector base |
| irq_req_o | output | 1 | Request to the core |
| vec_idx_o | output | IDX_W | Winning vector index |
| vec_addr_o | output | ADDR_W | Winning vector address |
| gie_o | output | 1 | Global enable state |
| flags_o | output | NUM_SRC | Stored flags |
| enables_o | output | NUM_SRC | Enable register |

## Verification
The bench builds the block with eight sources, a four-unit slot and a boot base of 0x400. With these values, both the lowest and the highest source index can be checked. A vector address in the boot area can also be told apart from one in the zero-based table. Because the slot is a power of two, the shift variant of the address generator is the one built. Mixing both source types in one run allows several checks side by side: a latched flag can be compared with a level pulse that was never served, and the hold-off can be observed while a flag is still pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        WR_ENABLE   = 1'b0,
        WR_FLAG_CLR = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
    input  logic src_i,
    input  logic is_level_i,
    input  logic flag_q_i,
    input  logic en_q_i,
    input  logic clr_i,
    output logic flag_d_o,
    output logic pend_o
);
    always_comb begin
        if (is_level_i) begin
            flag_d_o = 1'b0;
            pend_o   = en_q_i & src_i;
        end else begin
            flag_d_o = src_i | (flag_q_i & ~clr_i);
            pend_o   = en_q_i & flag_q_i;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i + 1);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int          IDX_W     = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SLOT_SIZE = 4,
    parameter int unsigned BOOT_BASE = 32'h400
) (
    input  logic              boot_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] BOOT_A = ADDR_W'(BOOT_BASE);
    localparam bit SLOT_POW2 = (SLOT_SIZE != 0) && ((SLOT_SIZE & (SLOT_SIZE - 1)) == 0);
    localparam int SLOT_SH   = $clog2(SLOT_SIZE);

    logic [ADDR_W-1:0] offs;
    generate
        if (SLOT_POW2) begin : g_shift
            assign offs = ADDR_W'(idx_i) << SLOT_SH;
        end else begin : g_mult
            assign offs = ADDR_W'(idx_i) * ADDR_W'(SLOT_SIZE);
        end
    endgenerate

    assign addr_o = (boot_i ? BOOT_A : '0) + offs;
endmodule

// File: rtl/prio_vec_irq.sv
module prio_vec_irq
    import irq_pkg::*;
#(
    parameter int          NUM_SRC   = 8,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SLOT_SIZE = 4,
    parameter int unsigned BOOT_BASE = 32'h400,
    localparam int         IDX_W     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] src_is_level_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               gie_set_i,
    input  logic               cli_i,
    input  logic               reti_i,
    input  logic               retire_i,
    input  logic               take_i,
    input  logic               boot_sel_i,
    output logic               irq_req_o,
    output logic [IDX_W-1:0]   vec_idx_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               gie_o,
    output logic [NUM_SRC-1:0] flags_o,
    output logic [NUM_SRC-1:0] enables_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_SRC-1:0] en;
        logic               gie;
        logic               hold;
    } irq_state_t;

    irq_state_t st_d, st_q;

    logic [NUM_SRC-1:0] pend, clr_vec, flag_nx;
    logic               any_pend, take_ok;
    wr_kind_e           wr_kind;

    assign wr_kind = wr_kind_e'(wr_sel_i);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign clr_vec[g] = (wr_en_i && wr_kind == WR_FLAG_CLR && wr_data_i[g])
                              | (take_ok && vec_idx_o == IDX_W'(g + 1));
            irq_src_cell u_cell (
                .src_i      (src_i[g]),
                .is_level_i (src_is_level_i[g]),
                .flag_q_i   (st_q.flag[g]),
                .en_q_i     (st_q.en[g]),
                .clr_i      (clr_vec[g]),
                .flag_d_o   (flag_nx[g]),
                .pend_o     (pend[g])
            );
        end
    endgenerate

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend_i (pend),
        .any_o  (any_pend),
        .idx_o  (vec_idx_o)
    );

    irq_vec_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .SLOT_SIZE(SLOT_SIZE),
                  .BOOT_BASE(BOOT_BASE)) u_vec (
        .boot_i (boot_sel_i),
        .idx_i  (vec_idx_o),
        .addr_o (vec_addr_o)
    );

    assign irq_req_o = st_q.gie & ~st_q.hold & ~cli_i & any_pend;
    assign take_ok   = take_i & irq_req_o;

    always_comb begin
        st_d      = st_q;
        st_d.flag = flag_nx;
        if (wr_en_i && wr_kind == WR_ENABLE) st_d.en = wr_data_i;
        if (gie_set_i || reti_i) st_d.gie = 1'b1;
        if (cli_i || take_ok)    st_d.gie = 1'b0;
        if (reti_i)              st_d.hold = 1'b1;
        else if (retire_i)       st_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gie_o     = st_q.gie;
    assign flags_o   = st_q.flag;
    assign enables_o = st_q.en;

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> gie_o); // R2
    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && irq_req_o) |=> !gie_o); // R3
    AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !cli_i && !(take_i && irq_req_o)) |=> gie_o); // R4
    AST_HOLD_AFTER_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reti_i) |-> !irq_req_o); // R8
    AST_CLI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cli_i |-> !irq_req_o); // R9
    AST_CLI_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        cli_i |=> !gie_o); // R9
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(src_is_level_i)) == '0)); // R7
endmodule

// File: tb/sim_prio_vec_irq.sv
`timescale 1ns/1ps
module sim_prio_vec_irq;
    localparam int N = 8;
    localparam int IW = 4;
    localparam int AW = 16;
    localparam int SLOT = 4;
    localparam int unsigned BOOT = 32'h400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] src = '0, lvl = '0, wdata = '0;
    logic wr_en = 0, wr_sel = 0, gie_set = 0, cli = 0, reti = 0, retire = 0, take = 0, boot = 0;
    logic irq_req, gie;
    logic [IW-1:0] vidx;
    logic [AW-1:0] vaddr;
    logic [N-1:0] flags, ens;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    prio_vec_irq #(.NUM_SRC(N), .ADDR_W(AW), .SLOT_SIZE(SLOT), .BOOT_BASE(BOOT)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .src_is_level_i(lvl),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wdata),
        .gie_set_i(gie_set), .cli_i(cli), .reti_i(reti), .retire_i(retire),
        .take_i(take), .boot_sel_i(boot), .irq_req_o(irq_req), .vec_idx_o(vidx),
        .vec_addr_o(vaddr), .gie_o(gie), .flags_o(flags), .enables_o(ens));

    // entry: {enable[7:0], src[7:0], expected vector index[3:0]}, all sources level type
    localparam logic [19:0] TBL [10] = '{
        {8'hFF, 8'h00, 4'd0}, {8'hFF, 8'h01, 4'd1}, {8'hFF, 8'h80, 4'd8},
        {8'hFF, 8'hA4, 4'd3}, {8'hFB, 8'hA4, 4'd6}, {8'h00, 8'hFF, 4'd0},
        {8'hF0, 8'h0F, 4'd0}, {8'hFF, 8'hFF, 4'd1}, {8'h7F, 8'h80, 4'd0},
        {8'h80, 8'h80, 4'd8}};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] d);
        wr_en = 1; wr_sel = sel; wdata = d;
        step();
        wr_en = 0; wdata = '0;
    endtask

    initial begin
        #100000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 req", {31'd0, irq_req}, 0);
        check("R11 gie", {31'd0, gie}, 0);
        check("R11 flags", {24'd0, flags}, 0);
        check("R11 en", {24'd0, ens}, 0);
        rst_n = 1;
        step();
        check("R11 req after release", {31'd0, irq_req}, 0);

        gie_set = 1; step(); gie_set = 0;
        check("R4 gie set by software", {31'd0, gie}, 1);

        lvl = '1;
        for (int k = 0; k < 10; k++) begin
            src = TBL[k][11:4];
            wr(1'b0, TBL[k][19:12]);
            #0.5;
            check($sformatf("R1 R2 table %0d idx", k), {28'd0, vidx}, {28'd0, TBL[k][3:0]});
            check($sformatf("R2 table %0d req", k), {31'd0, irq_req}, {31'd0, TBL[k][3:0] != 0});
            check($sformatf("R10 table %0d addr", k), {16'd0, vaddr}, TBL[k][3:0] * SLOT);
        end
        src = '0; lvl = '0;
        wr(1'b0, 8'h00);

        src[2] = 1; step(); src = '0;
        check("R5 flag latched while disabled", {24'd0, flags}, 32'h04);
        check("R5 no request while disabled", {31'd0, irq_req}, 0);
        src[5] = 1; step(); src = '0;
        wr(1'b0, 8'hFF);
        check("R5 served once enabled", {31'd0, irq_req}, 1);
        check("R1 lower index wins", {28'd0, vidx}, 3);

        take = 1; step(); take = 0;
        check("R3 flag cleared on take", {24'd0, flags}, 32'h20);
        check("R3 gie cleared on take", {31'd0, gie}, 0);
        check("R2 no request with gie off", {31'd0, irq_req}, 0);

        reti = 1; step(); reti = 0;
        check("R4 gie set by return", {31'd0, gie}, 1);
        check("R8 held after return", {31'd0, irq_req}, 0);
        step();
        check("R8 still held", {31'd0, irq_req}, 0);
        retire = 1; step(); retire = 0;
        check("R8 released after retire", {31'd0, irq_req}, 1);
        check("R8 pending index", {28'd0, vidx}, 6);

        cli = 1; take = 1; #0.5;
        check("R9 same-cycle block", {31'd0, irq_req}, 0);
        @(negedge clk); cli = 0; take = 0;
        check("R9 gie cleared", {31'd0, gie}, 0);
        check("R9 take ignored, flag kept", {24'd0, flags}, 32'h20);

        wr(1'b1, 8'h20);
        check("R6 write-one-to-clear", {24'd0, flags}, 0);
        src[1] = 1; wr(1'b1, 8'h02); src = '0;
        check("R6 event beats clear", {24'd0, flags}, 32'h02);
        wr(1'b1, 8'hFF);
        check("R6 all cleared", {24'd0, flags}, 0);
        check("R6 enables untouched", {24'd0, ens}, 32'hFF);

        lvl = 8'h08;
        wr(1'b0, 8'h00);
        src[3] = 1; step(); src = '0;
        wr(1'b0, 8'hFF);
        gie_set = 1; step(); gie_set = 0;
        check("R7 level pulse not stored", {24'd0, flags}, 0);
        check("R7 level pulse never served", {31'd0, irq_req}, 0);
        src[3] = 1; #0.5;
        check("R7 level request while high", {28'd0, vidx}, 4);
        check("R10 zero base", {16'd0, vaddr}, 32'h10);
        boot = 1; #0.5;
        check("R10 boot base", {16'd0, vaddr}, BOOT + 4 * SLOT);
        boot = 0; src = '0;
        step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule